// File: doc/BRIEF.md
# Dual-Adapter Interrupt Level Arbiter

This block joins the interrupt requests of peripherals sitting behind two bus adapters into a single priority-interrupt system. Each request has one bit in a 32-bit pending vector. A request is set from a per-bit set input, and it stays pending until an acknowledge picks it. Each adapter sorts its request bits into two fixed groups, using two masks fixed at build time. The high group carries the bus priorities 7 and 6. The low group carries the bus priorities 5 and 4. For each adapter, software programs one 3-bit processor level for the high group and one for the low group.

From the pending vector and the programmed levels, the block drives a one-hot-per-level mask that goes to the processor's priority logic. When the processor acknowledges a level, it sends that level on a valid/ready acknowledge channel. The block then finds the winning request and clears it. It answers on a valid/ready response channel with the device vector and the adapter tag.

An acknowledge is accepted (`ack_ready` high) only when the response register is empty or is being drained in the same cycle. A response that is not taken holds its value unchanged until `rsp_ready` is seen high.

Top module: `irq_lvl_arbiter`

## Requirements
- R1: While any pending request lies in an adapter's high group, bit L of `lvl_mask` is 1, where L is that adapter's high level field. The default high groups are bits 7:6 for adapter 0 and bits 17:16 for adapter 1.
- R2: While any pending request lies in an adapter's low group, bit L of `lvl_mask` is 1, where L is that adapter's low level field. The default low groups are bits 5:4 for adapter 0 and bits 26:24 for adapter 1.
- R3: `lvl_mask` is the OR of the one-hot codes of the levels of all groups that have a pending request. It is 0 when nothing is pending, and it changes in the cycle after the pending vector or a level field changes.
- R4: An acknowledge at level L scans the adapters in the order 0 then 1. Within each adapter it checks the high group before the low group. The first group whose level equals L and which has a pending request wins.
- R5: Within the winning group, the lowest-numbered pending bit wins, and that bit is cleared from the pending vector at the clock edge that accepts the acknowledge.
- R6: For a winning request, `rsp_tag` is 2*adapter+1, so adapter 0 reports 1 and adapter 1 reports 3.
- R7: If no group at level L has a pending request, the response carries `rsp_vec` = 0 and `rsp_tag` = 0, and the pending vector is left unchanged.
- R8: The vector of request bit b is 0x100 + 4*b when b has a device (default device bits 6, 7, 16, 17, 24, 25, 26). Otherwise the vector is 0, and the bit is still cleared when it wins.
- R9: When a bit is set through `req_set` in the same cycle that an acknowledge clears it, the bit stays pending.
- R10: A synchronous reset clears the pending vector, all level fields and `rsp_valid`, so `lvl_mask` reads 0 after reset.
- R11: While `rsp_valid` is 1 and `rsp_ready` is 0, `ack_ready` is 0 and `rsp_vec`/`rsp_tag` hold their values. The response appears in the cycle after the acknowledge is accepted.
- R12: A level write (`cfg_we`) replaces both level fields of adapter `cfg_adp`, starting from the next cycle. An acknowledge in the same cycle as the write still uses the old fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_set | input | 32 | Per-bit request set, sampled every clock |
| cfg_we | input | 1 | Level field write strobe |
| cfg_adp | input | 1 | Adapter selected by the write |
| cfg_hi_lvl | input | 3 | New high-group level |
| cfg_lo_lvl | input | 3 | New low-group level |
| lvl_mask | output | 8 | One bit per processor level with a pending request |
| ack_valid | input | 1 | Acknowledge request valid |
| ack_ready | output | 1 | Acknowledge accepted this cycle when valid |
| ack_lvl | input | 3 | Level being acknowledged |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken this cycle when valid |
| rsp_vec | output | 10 | Device vector of the winning request, or 0 |
| rsp_tag | output | 2 | Adapter tag (1 or 3), 0 when nothing won |

## Verification
The assertions assume that the high and low masks of all adapters are pairwise disjoint. They also assume that `cfg_adp` names an existing adapter and that `ack_lvl` and the level fields stay within the 3-bit range. With overlapping masks, one bit could win through two groups, and the clear and level checks would then no longer describe one request. The stimulus uses only the default disjoint masks and adapter indices 0 and 1. It drives every input just after the falling edge, so every acknowledge, level write and set is a clean single-cycle event.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
  typedef enum logic {GRP_HI = 1'b0, GRP_LO = 1'b1} grp_e;

  // one-hot code of a level value
  function automatic logic [255:0] lvl_onehot(input int unsigned lvl);
    logic [255:0] r;
    r = '0;
    r[lvl[7:0]] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/irq_lvl_cfg.sv
module irq_lvl_cfg #(
  parameter int NADP = 2,
  parameter int LVLW = 3,
  localparam int AW = (NADP > 1) ? $clog2(NADP) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [AW-1:0]        cfg_adp,
  input  logic [LVLW-1:0]      cfg_hi_lvl,
  input  logic [LVLW-1:0]      cfg_lo_lvl,
  output logic [NADP*LVLW-1:0] hi_lvls,
  output logic [NADP*LVLW-1:0] lo_lvls
);
  logic [NADP-1:0][LVLW-1:0] hi_q, lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (cfg_we) begin
      hi_q[cfg_adp] <= cfg_hi_lvl;
      lo_q[cfg_adp] <= cfg_lo_lvl;
    end
  end

  assign hi_lvls = hi_q;
  assign lo_lvls = lo_q;

  // R12
  cfg_write_takes_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (hi_q[$past(cfg_adp)] == $past(cfg_hi_lvl)) &&
               (lo_q[$past(cfg_adp)] == $past(cfg_lo_lvl)));
endmodule

// File: rtl/irq_req_reg.sv
module irq_req_reg #(
  parameter int NREQ = 32,
  localparam int IDXW = $clog2(NREQ)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREQ-1:0] req_set,
  input  logic            clr_en,
  input  logic [IDXW-1:0] clr_idx,
  output logic [NREQ-1:0] req_q
);
  logic [NREQ-1:0] clr_vec;

  always_comb begin
    clr_vec = '0;
    if (clr_en) clr_vec[clr_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) req_q <= '0;
    else     req_q <= (req_q & ~clr_vec) | req_set;
  end

  // R9
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (req_set != '0) |=> ((req_q & $past(req_set)) == $past(req_set)));
endmodule

// File: rtl/irq_lvl_map.sv
module irq_lvl_map #(
  parameter int NREQ = 32,
  parameter int NADP = 2,
  parameter int LVLW = 3,
  localparam int NLVL = 1 << LVLW
) (
  input  logic [NREQ-1:0]      req_q,
  input  logic [NADP*NREQ-1:0] hi_masks,
  input  logic [NADP*NREQ-1:0] lo_masks,
  input  logic [NADP*LVLW-1:0] hi_lvls,
  input  logic [NADP*LVLW-1:0] lo_lvls,
  output logic [NLVL-1:0]      lvl_mask
);
  logic [NADP-1:0][NLVL-1:0] part_hi, part_lo;

  for (genvar a = 0; a < NADP; a++) begin : g_adp
    logic act_hi, act_lo;
    assign act_hi = |(req_q & hi_masks[a*NREQ +: NREQ]);
    assign act_lo = |(req_q & lo_masks[a*NREQ +: NREQ]);
    always_comb begin
      part_hi[a] = '0;
      part_lo[a] = '0;
      if (act_hi) part_hi[a][hi_lvls[a*LVLW +: LVLW]] = 1'b1;
      if (act_lo) part_lo[a][lo_lvls[a*LVLW +: LVLW]] = 1'b1;
    end
  end

  always_comb begin
    lvl_mask = '0;
    for (int a = 0; a < NADP; a++) lvl_mask = lvl_mask | part_hi[a] | part_lo[a];
  end
endmodule

// File: rtl/irq_ack_pick.sv
module irq_ack_pick
  import irq_lvl_pkg::*;
#(
  parameter int NREQ = 32,
  parameter int NADP = 2,
  parameter int LVLW = 3,
  parameter int VECW = 10,
  parameter logic [NREQ-1:0] DEV_MASK = 32'h0703_00C0,
  parameter int VEC_BASE = 'h100,
  parameter int VEC_STEP = 4,
  localparam int IDXW = $clog2(NREQ),
  localparam int AW = (NADP > 1) ? $clog2(NADP) : 1,
  localparam int TAGW = AW + 1
) (
  input  logic [NREQ-1:0]      req_q,
  input  logic [LVLW-1:0]      ack_lvl,
  input  logic [NADP*NREQ-1:0] hi_masks,
  input  logic [NADP*NREQ-1:0] lo_masks,
  input  logic [NADP*LVLW-1:0] hi_lvls,
  input  logic [NADP*LVLW-1:0] lo_lvls,
  output logic                 hit,
  output logic [IDXW-1:0]      win_idx,
  output logic [TAGW-1:0]      win_tag,
  output logic [VECW-1:0]      win_vec
);
  logic [NREQ-1:0] sel_mask;
  logic [AW-1:0]   sel_adp;
  grp_e            sel_grp;

  // group scan: adapters ascending, high before low
  always_comb begin
    hit      = 1'b0;
    sel_mask = '0;
    sel_adp  = '0;
    sel_grp  = GRP_HI;
    for (int a = 0; a < NADP; a++) begin
      if (!hit && hi_lvls[a*LVLW +: LVLW] == ack_lvl &&
          |(req_q & hi_masks[a*NREQ +: NREQ])) begin
        hit      = 1'b1;
        sel_mask = req_q & hi_masks[a*NREQ +: NREQ];
        sel_adp  = AW'(a);
        sel_grp  = GRP_HI;
      end
      if (!hit && lo_lvls[a*LVLW +: LVLW] == ack_lvl &&
          |(req_q & lo_masks[a*NREQ +: NREQ])) begin
        hit      = 1'b1;
        sel_mask = req_q & lo_masks[a*NREQ +: NREQ];
        sel_adp  = AW'(a);
        sel_grp  = GRP_LO;
      end
    end
  end

  // lowest pending bit of the chosen group
  always_comb begin
    win_idx = '0;
    for (int b = NREQ - 1; b >= 0; b--) begin
      if (sel_mask[b]) win_idx = IDXW'(b);
    end
  end

  always_comb begin
    win_tag = hit ? {sel_adp, 1'b1} : '0;
    if (hit && DEV_MASK[win_idx])
      win_vec = VECW'(VEC_BASE + VEC_STEP * int'(win_idx));
    else
      win_vec = '0;
  end

  // group kind is kept for visibility of the scan result
  logic unused_grp;
  assign unused_grp = (sel_grp == GRP_LO);
endmodule

// File: rtl/irq_lvl_arbiter.sv
module irq_lvl_arbiter #(
  parameter int NREQ = 32,
  parameter int NADP = 2,
  parameter int LVLW = 3,
  parameter int VECW = 10,
  parameter logic [NADP*NREQ-1:0] HI_MASKS = 64'h0003_0000_0000_00C0,
  parameter logic [NADP*NREQ-1:0] LO_MASKS = 64'h0700_0000_0000_0030,
  parameter logic [NREQ-1:0] DEV_MASK = 32'h0703_00C0,
  parameter int VEC_BASE = 'h100,
  parameter int VEC_STEP = 4,
  localparam int NLVL = 1 << LVLW,
  localparam int IDXW = $clog2(NREQ),
  localparam int AW = (NADP > 1) ? $clog2(NADP) : 1,
  localparam int TAGW = AW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREQ-1:0] req_set,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_adp,
  input  logic [LVLW-1:0] cfg_hi_lvl,
  input  logic [LVLW-1:0] cfg_lo_lvl,
  output logic [NLVL-1:0] lvl_mask,
  input  logic            ack_valid,
  output logic            ack_ready,
  input  logic [LVLW-1:0] ack_lvl,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [VECW-1:0] rsp_vec,
  output logic [TAGW-1:0] rsp_tag
);
  logic [NREQ-1:0]      req_q;
  logic [NADP*LVLW-1:0] hi_lvls, lo_lvls;
  logic                 pick_hit;
  logic [IDXW-1:0]      pick_idx;
  logic [TAGW-1:0]      pick_tag;
  logic [VECW-1:0]      pick_vec;
  logic                 accept;

  assign ack_ready = !rsp_valid || rsp_ready;
  assign accept    = ack_valid && ack_ready;

  irq_lvl_cfg #(.NADP(NADP), .LVLW(LVLW)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_adp(cfg_adp),
    .cfg_hi_lvl(cfg_hi_lvl), .cfg_lo_lvl(cfg_lo_lvl),
    .hi_lvls(hi_lvls), .lo_lvls(lo_lvls)
  );

  irq_req_reg #(.NREQ(NREQ)) u_req (
    .clk(clk), .rst(rst), .req_set(req_set),
    .clr_en(accept && pick_hit), .clr_idx(pick_idx), .req_q(req_q)
  );

  irq_lvl_map #(.NREQ(NREQ), .NADP(NADP), .LVLW(LVLW)) u_map (
    .req_q(req_q), .hi_masks(HI_MASKS), .lo_masks(LO_MASKS),
    .hi_lvls(hi_lvls), .lo_lvls(lo_lvls), .lvl_mask(lvl_mask)
  );

  irq_ack_pick #(
    .NREQ(NREQ), .NADP(NADP), .LVLW(LVLW), .VECW(VECW),
    .DEV_MASK(DEV_MASK), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_pick (
    .req_q(req_q), .ack_lvl(ack_lvl), .hi_masks(HI_MASKS), .lo_masks(LO_MASKS),
    .hi_lvls(hi_lvls), .lo_lvls(lo_lvls), .hit(pick_hit), .win_idx(pick_idx),
    .win_tag(pick_tag), .win_vec(pick_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_vec   <= '0;
      rsp_tag   <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_vec   <= pick_vec;
      rsp_tag   <= pick_tag;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_vec) && $stable(rsp_tag)));

  // R5
  win_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && pick_hit && !req_set[pick_idx]) |=> !req_q[$past(pick_idx)]);

  // R7
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !pick_hit) |=> (rsp_vec == '0 && rsp_tag == '0));

  // R3
  idle_no_level_chk: assert property (@(posedge clk) disable iff (rst)
    (req_q == '0) |-> (lvl_mask == '0));

  // R6
  tag_odd_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_tag != '0) |-> rsp_tag[0]);
endmodule

// File: tb/tb_irq_lvl_arbiter.sv
module tb_irq_lvl_arbiter;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] req_set;
  logic        cfg_we;
  logic [0:0]  cfg_adp;
  logic [2:0]  cfg_hi_lvl, cfg_lo_lvl;
  logic [7:0]  lvl_mask;
  logic        ack_valid, ack_ready;
  logic [2:0]  ack_lvl;
  logic        rsp_valid, rsp_ready;
  logic [9:0]  rsp_vec;
  logic [1:0]  rsp_tag;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_lvl_arbiter dut (
    .clk(clk), .rst(rst), .req_set(req_set), .cfg_we(cfg_we), .cfg_adp(cfg_adp),
    .cfg_hi_lvl(cfg_hi_lvl), .cfg_lo_lvl(cfg_lo_lvl), .lvl_mask(lvl_mask),
    .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_lvl(ack_lvl),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_vec(rsp_vec), .rsp_tag(rsp_tag)
  );

  // reference model
  bit [31:0] m_hi_grp [2] = '{32'h0000_00C0, 32'h0003_0000};
  bit [31:0] m_lo_grp [2] = '{32'h0000_0030, 32'h0700_0000};
  int        m_hi [2];
  int        m_lo [2];
  bit [31:0] m_req;
  bit        m_rv;
  int        m_vec, m_tag;

  function automatic int dev_vec(int b);
    if (b == 6 || b == 7 || b == 16 || b == 17 || b == 24 || b == 25 || b == 26)
      return 'h100 + 4 * b;
    return 0;
  endfunction

  function automatic int model_lvl();
    int r = 0;
    for (int a = 0; a < 2; a++) begin
      if ((m_req & m_hi_grp[a]) != 0) r |= (1 << m_hi[a]);
      if ((m_req & m_lo_grp[a]) != 0) r |= (1 << m_lo[a]);
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_req = 0; m_rv = 0; m_vec = 0; m_tag = 0;
      for (int a = 0; a < 2; a++) begin m_hi[a] = 0; m_lo[a] = 0; end
    end else begin
      bit acc;
      bit [31:0] grp;
      int wadp, wbit;
      acc = ack_valid && (!m_rv || rsp_ready);
      grp = 0; wadp = -1; wbit = -1;
      for (int a = 0; a < 2; a++) begin
        if (wadp < 0 && m_hi[a] == int'(ack_lvl) && (m_req & m_hi_grp[a]) != 0) begin
          wadp = a; grp = m_req & m_hi_grp[a];
        end
        if (wadp < 0 && m_lo[a] == int'(ack_lvl) && (m_req & m_lo_grp[a]) != 0) begin
          wadp = a; grp = m_req & m_lo_grp[a];
        end
      end
      for (int b = 31; b >= 0; b--) if (grp[b]) wbit = b;
      if (acc) begin
        m_rv = 1;
        if (wadp >= 0) begin
          m_req[wbit] = 1'b0;
          m_vec = dev_vec(wbit); m_tag = 2 * wadp + 1;
        end else begin
          m_vec = 0; m_tag = 0;
        end
      end else if (rsp_ready) m_rv = 0;
      m_req = m_req | req_set;
      if (cfg_we) begin m_hi[cfg_adp] = int'(cfg_hi_lvl); m_lo[cfg_adp] = int'(cfg_lo_lvl); end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (int'(lvl_mask) != model_lvl()) begin
        errors++;
        $display("FAIL R3 model lvl_mask got %h exp %h", lvl_mask, model_lvl());
      end
      checks++;
      if (rsp_valid != m_rv || (m_rv && (int'(rsp_vec) != m_vec || int'(rsp_tag) != m_tag))) begin
        errors++;
        $display("FAIL R4 model rsp got v%0d %h/%0d exp v%0d %h/%0d",
                 rsp_valid, rsp_vec, rsp_tag, m_rv, m_vec, m_tag);
      end
    end
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic set_bits(bit [31:0] m);
    @(negedge clk); req_set = m;
    @(negedge clk); req_set = '0;
  endtask

  task automatic do_ack(int l);
    @(negedge clk); ack_valid = 1'b1; ack_lvl = 3'(l);
    @(negedge clk); ack_valid = 1'b0;
  endtask

  task automatic write_lvl(int a, int h, int l);
    @(negedge clk); cfg_we = 1'b1; cfg_adp = 1'(a); cfg_hi_lvl = 3'(h); cfg_lo_lvl = 3'(l);
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_set = '0; cfg_we = 1'b0; cfg_adp = '0; cfg_hi_lvl = '0;
    cfg_lo_lvl = '0; ack_valid = 1'b0; ack_lvl = '0; rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 lvl_mask after reset", int'(lvl_mask), 0);
    chk("R10 rsp_valid after reset", int'(rsp_valid), 0);

    write_lvl(0, 5, 3);
    write_lvl(1, 5, 2);
    chk("R12 fields idle no level", int'(lvl_mask), 0);

    set_bits(32'h0001_00C0);
    chk("R1 high groups at level 5", int'(lvl_mask), 'h20);
    set_bits(32'h0000_0010);
    chk("R2 low group a0 level 3", int'(lvl_mask), 'h28);
    set_bits(32'h0100_0000);
    chk("R3 OR of all levels", int'(lvl_mask), 'h2C);

    do_ack(5);
    chk("R5 lowest bit 6 vector", int'(rsp_vec), 'h118);
    chk("R6 tag adapter 0", int'(rsp_tag), 1);
    do_ack(5);
    chk("R5 next bit 7 vector", int'(rsp_vec), 'h11C);
    do_ack(5);
    chk("R4 scan reaches adapter 1 high", int'(rsp_vec), 'h140);
    chk("R6 tag adapter 1", int'(rsp_tag), 3);
    chk("R5 cleared high groups", int'(lvl_mask), 'h0C);

    do_ack(3);
    chk("R8 no-device bit vector", int'(rsp_vec), 0);
    chk("R8 no-device bit tag", int'(rsp_tag), 1);
    chk("R8 no-device bit cleared", int'(lvl_mask), 'h04);

    do_ack(6);
    chk("R7 empty level vector", int'(rsp_vec), 0);
    chk("R7 empty level tag", int'(rsp_tag), 0);
    chk("R7 pending unchanged", int'(lvl_mask), 'h04);

    @(negedge clk); rsp_ready = 1'b0;
    do_ack(2);
    for (int i = 0; i < 3; i++) begin
      chk("R11 held valid", int'(rsp_valid), 1);
      chk("R11 held vector", int'(rsp_vec), 'h160);
      chk("R11 ack blocked", int'(ack_ready), 0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R11 drained", int'(rsp_valid), 0);

    set_bits(32'h0100_0000);
    @(negedge clk); ack_valid = 1'b1; ack_lvl = 3'd2; req_set = 32'h0100_0000;
    @(negedge clk); ack_valid = 1'b0; req_set = '0;
    chk("R9 set wins vector", int'(rsp_vec), 'h160);
    chk("R9 set wins still pending", int'(lvl_mask), 'h04);

    write_lvl(1, 5, 7);
    chk("R12 new low level", int'(lvl_mask), 'h80);
    do_ack(7);
    chk("R12 ack at new level", int'(rsp_vec), 'h160);
    chk("R3 all clear", int'(lvl_mask), 0);

    set_bits(32'h0600_0000);
    do_ack(7);
    chk("R5 lowest of 26:25", int'(rsp_vec), 'h164);
    do_ack(7);
    chk("R8 bit 26 vector", int'(rsp_vec), 'h168);

    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule